// File: doc/BRIEF.md
# UART Receive FIFO Status and Error Tracker

This block sits between the bit-level receiver of a UART channel and the host. Completed characters arrive as single-cycle events that carry a data byte and break, framing and parity flags. They are kept in a first-in first-out store. Behind a full store sits one extra holding register, so the channel can keep one character more than the store depth before data is lost. The host reads the oldest character through a read strobe. The block reports receiver-ready, store-full, overrun, framing, parity and break status, plus a break-change interrupt flag.

A break is stored as one zero entry. After that, all further characters are thrown away until the line has been marking for at least half a bit time. A two-state machine tracks this. In state `BRK_HUNT` characters load normally. The transition *break accepted* (`BRK_HUNT` to `BRK_BLOCK`) fires when a character flagged as a break completes. In state `BRK_BLOCK` every completed character is dropped. The transition *line marking* (`BRK_BLOCK` to `BRK_HUNT`) fires when `line_mark` is high. A reset-receiver command forces `BRK_HUNT` from either state. Both named transitions raise the break-change flag.

The break, framing and parity status bits can follow one of two sides of the store. In the default mode they take the flags of each character as the host reads it. In load-accumulate mode they take the flags of each character as it enters the store. Single-cycle command inputs switch between the modes, clear the error bits, clear the break-change flag and empty the receiver.

Top module: `rx_status_tracker`

## Requirements
- R1: After reset, `rx_rdy`, `rx_full`, `st_overrun`, `st_frame`, `st_parity`, `st_break` and `brk_chg_irq` are all 0, and the error bits follow the read side.
- R2: `rx_rdy` rises in the cycle after a character enters the store. It falls after the read that leaves the store empty. A read strobe on an empty store has no effect.
- R3: Characters leave in arrival order, and `rd_data` always shows the oldest one. A load and a read in the same cycle leave the occupancy unchanged.
- R4: `rx_full` rises when a load fills the store, and a further character then waits in the holding register. A read with a character in the holding register moves that character into the store in the same cycle, so `rx_full` stays 1 until the second read.
- R5: `start_bit` while the store is full and the holding register is occupied (and no read happens in that cycle) sets `st_overrun`. The next completed character and its flags are then discarded.
- R6: In read-side mode (default), a read sets any of `st_break`, `st_frame` and `st_parity` whose flag is 1 on the character read. The bits stay set until cleared.
- R7: `cmd_acc_load` selects load-accumulate mode. In that mode the three bits are set from the flags of each character as it enters the store. `cmd_acc_read` returns to read-side mode.
- R8: `cmd_rst_err` clears `st_break`, `st_frame`, `st_parity` and `st_overrun`. The clear wins over a set in the same cycle.
- R9: A completed character flagged as a break stores exactly one entry with data 0x00 and break flag 1. All later completed characters are dropped until `line_mark` is seen high.
- R10: `brk_chg_irq` is set when a break is accepted and when `line_mark` ends the blocked state. `cmd_rst_brkchg` clears it, and a set wins over a clear in the same cycle.
- R11: `cmd_rst_rx` empties the store and the holding register, cancels a pending discard and returns the break machine to `BRK_HUNT`. It does not change the error bits.
- R12: While `rx_enable` is 0, `char_done` and `start_bit` are ignored and the stored characters are kept. Characters completed after re-enabling are appended behind them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enable level |
| start_bit | input | 1 | Pulse: a start bit of a new character was seen |
| char_done | input | 1 | Pulse: a character completed |
| char_data | input | 8 | Data of the completed character |
| char_fe | input | 1 | Framing-error flag of the completed character |
| char_pe | input | 1 | Parity-error flag of the completed character |
| char_brk | input | 1 | Break flag of the completed character |
| line_mark | input | 1 | Line has been marking for at least half a bit time |
| rd_stb | input | 1 | Pulse: host reads the oldest character |
| cmd_rst_rx | input | 1 | Command pulse: reset receiver |
| cmd_rst_err | input | 1 | Command pulse: reset error status |
| cmd_rst_brkchg | input | 1 | Command pulse: clear break-change flag |
| cmd_acc_load | input | 1 | Command pulse: select load-accumulate mode |
| cmd_acc_read | input | 1 | Command pulse: select read-side mode |
| rd_data | output | 8 | Data of the oldest stored character |
| rx_rdy | output | 1 | At least one character stored |
| rx_full | output | 1 | Store holds DEPTH characters |
| st_overrun | output | 1 | Overrun status |
| st_frame | output | 1 | Framing-error status |
| st_parity | output | 1 | Parity-error status |
| st_break | output | 1 | Received-break status |
| brk_chg_irq | output | 1 | Break-change interrupt flag |

## Verification
Each event or command is sampled on one rising edge. Every registered status bit, and the break-change flag, has its new value right after that same edge. `rd_data` follows the head of the store combinationally, so it changes at the same edge. The bench therefore drives each stimulus on a falling edge, removes it on the next falling edge, and reads all outputs at that second falling edge, exactly one cycle later. Facts that cannot be seen in a single output, such as a dropped character, are checked through the order of the data that later reads return.

// File: rtl/rxst_pkg.sv
package rxst_pkg;

    localparam int unsigned RXST_DW = 8;

    typedef struct packed {
        logic               brk;
        logic               fe;
        logic               pe;
        logic [RXST_DW-1:0] data;
    } rx_ent_t;

    typedef enum logic {
        BRK_HUNT  = 1'b0,
        BRK_BLOCK = 1'b1
    } brk_state_e;

endpackage

// File: rtl/rxst_fifo.sv
module rxst_fifo
    import rxst_pkg::*;
#(
    parameter  int unsigned DEPTH = 256,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  rx_ent_t       push_ent,
    input  logic          pop,
    output rx_ent_t       head,
    output logic [CW-1:0] count,
    output logic          full
);

    rx_ent_t         mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic            do_push;
    logic            do_pop;

    assign do_push = push & ~clr;
    assign do_pop  = pop & ~clr;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_ent;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= step_ptr(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rd_ptr];
    assign full = (count == CW'(DEPTH));

    // R3: occupancy never exceeds the depth
    a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R3: no write into a full store unless a read frees a slot
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && !pop && full));

    // R11: a clear leaves the store empty
    a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

endmodule

// File: rtl/rxst_brk_fsm.sv
module rxst_brk_fsm
    import rxst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic brk_char,
    input  logic line_mark,
    input  logic chg_clr,
    output logic blocked,
    output logic brk_chg
);

    brk_state_e state;
    brk_state_e state_n;
    logic       chg_n;
    logic       moved;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= BRK_HUNT;
            brk_chg <= 1'b0;
        end else begin
            state   <= state_n;
            brk_chg <= chg_n;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            BRK_HUNT:  if (brk_char)  state_n = BRK_BLOCK;
            BRK_BLOCK: if (line_mark) state_n = BRK_HUNT;
        endcase
        if (clr) state_n = BRK_HUNT;
    end

    always_comb begin
        blocked = (state == BRK_BLOCK);
        moved   = ~clr & (state_n != state);
        if (moved)        chg_n = 1'b1;
        else if (chg_clr) chg_n = 1'b0;
        else              chg_n = brk_chg;
    end

    // R10: accepting a break raises the change flag and blocks loading
    a_r10_flag_on_break: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && state == BRK_HUNT && brk_char) |=> (brk_chg && blocked));

    // R10: end of break raises the change flag and unblocks loading
    a_r10_flag_on_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && state == BRK_BLOCK && line_mark) |=> (brk_chg && !blocked));

endmodule

// File: rtl/rx_status_tracker.sv
module rx_status_tracker
    import rxst_pkg::*;
#(
    parameter  int unsigned DEPTH = 256,
    localparam int unsigned DW    = RXST_DW,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_enable,
    input  logic          start_bit,
    input  logic          char_done,
    input  logic [DW-1:0] char_data,
    input  logic          char_fe,
    input  logic          char_pe,
    input  logic          char_brk,
    input  logic          line_mark,
    input  logic          rd_stb,
    input  logic          cmd_rst_rx,
    input  logic          cmd_rst_err,
    input  logic          cmd_rst_brkchg,
    input  logic          cmd_acc_load,
    input  logic          cmd_acc_read,
    output logic [DW-1:0] rd_data,
    output logic          rx_rdy,
    output logic          rx_full,
    output logic          st_overrun,
    output logic          st_frame,
    output logic          st_parity,
    output logic          st_break
    ,output logic         brk_chg_irq
);

    rx_ent_t       new_ent;
    rx_ent_t       head;
    rx_ent_t       hold;
    rx_ent_t       hold_n;
    rx_ent_t       push_ent;
    logic          hold_vld;
    logic          hold_vld_n;
    logic          discard;
    logic          mode_load;
    logic [CW-1:0] count;
    logic          full;
    logic          blocked;
    logic          char_ev;
    logic          start_ev;
    logic          cand;
    logic          lost;
    logic          acc;
    logic          pop;
    logic          push;
    logic          ovr_hit;
    logic          ovr_arm;

    assign char_ev  = char_done & rx_enable;
    assign start_ev = start_bit & rx_enable;

    always_comb begin
        new_ent.brk  = char_brk;
        new_ent.fe   = char_brk ? 1'b0 : char_fe;
        new_ent.pe   = char_brk ? 1'b0 : char_pe;
        new_ent.data = char_brk ? '0 : char_data;
    end

    rxst_brk_fsm u_brk (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cmd_rst_rx),
        .brk_char  (char_ev & char_brk),
        .line_mark (line_mark),
        .chg_clr   (cmd_rst_brkchg),
        .blocked   (blocked),
        .brk_chg   (brk_chg_irq)
    );

    assign pop     = rd_stb & (count != '0);
    assign cand    = char_ev & ~blocked;
    assign lost    = cand & (discard | (full & hold_vld & ~pop));
    assign acc     = cand & ~lost;
    assign ovr_arm = start_ev & full & hold_vld & ~pop;
    assign ovr_hit = ovr_arm | (cand & ~discard & full & hold_vld & ~pop);

    always_comb begin
        push       = 1'b0;
        push_ent   = new_ent;
        hold_n     = hold;
        hold_vld_n = hold_vld;
        if (hold_vld && pop) begin
            push     = 1'b1;
            push_ent = hold;
            if (acc) hold_n     = new_ent;
            else     hold_vld_n = 1'b0;
        end else if (acc && (!full || pop)) begin
            push = 1'b1;
        end else if (acc) begin
            hold_n     = new_ent;
            hold_vld_n = 1'b1;
        end
    end

    rxst_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cmd_rst_rx),
        .push     (push),
        .push_ent (push_ent),
        .pop      (pop),
        .head     (head),
        .count    (count),
        .full     (full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold     <= '0;
            hold_vld <= 1'b0;
            discard  <= 1'b0;
        end else if (cmd_rst_rx) begin
            hold_vld <= 1'b0;
            discard  <= 1'b0;
        end else begin
            hold     <= hold_n;
            hold_vld <= hold_vld_n;
            if (!rx_enable)  discard <= 1'b0;
            else if (ovr_arm) discard <= 1'b1;
            else if (cand)    discard <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_load <= 1'b0;
        end else if (cmd_acc_load) begin
            mode_load <= 1'b1;
        end else if (cmd_acc_read) begin
            mode_load <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_overrun <= 1'b0;
            st_frame   <= 1'b0;
            st_parity  <= 1'b0;
            st_break   <= 1'b0;
        end else if (cmd_rst_err) begin
            st_overrun <= 1'b0;
            st_frame   <= 1'b0;
            st_parity  <= 1'b0;
            st_break   <= 1'b0;
        end else if (!cmd_rst_rx) begin
            if (ovr_hit) st_overrun <= 1'b1;
            if (mode_load && push) begin
                st_frame  <= st_frame  | push_ent.fe;
                st_parity <= st_parity | push_ent.pe;
                st_break  <= st_break  | push_ent.brk;
            end else if (!mode_load && pop) begin
                st_frame  <= st_frame  | head.fe;
                st_parity <= st_parity | head.pe;
                st_break  <= st_break  | head.brk;
            end
        end
    end

    assign rd_data = head.data;
    assign rx_rdy  = (count != '0);
    assign rx_full = full;

    // R4: the holding register is only in use behind a full store
    a_r4_hold_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        hold_vld |-> full);

    // R5: an overrun event is reported on the next cycle
    a_r5_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_hit && !cmd_rst_err) |=> st_overrun);

    // R9: while blocked after a break, no new character reaches the store
    a_r9_blocked_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && char_done && !pop) |-> !push);

    // R8: reset error status clears all four bits
    a_r8_error_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst_err |=> !(st_overrun || st_frame || st_parity || st_break));

    // R11: reset receiver drops the holding register
    a_r11_hold_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst_rx |=> !hold_vld);

endmodule

// File: tb/sim_rx_status_tracker.sv
`timescale 1ns/1ps
module sim_rx_status_tracker;

    localparam int DEPTH = 4;
    localparam logic [4:0] C_NONE  = 5'b00000;
    localparam logic [4:0] C_RX    = 5'b00001;
    localparam logic [4:0] C_ERR   = 5'b00010;
    localparam logic [4:0] C_CHG   = 5'b00100;
    localparam logic [4:0] C_LOADM = 5'b01000;
    localparam logic [4:0] C_READM = 5'b10000;

    // vector: {load, read, data[7:0], exp_rdy, exp_full, exp_head[7:0]}
    localparam int NV = 10;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h11, 1'b1, 1'b0, 8'h11},
        {1'b1, 1'b0, 8'h22, 1'b1, 1'b0, 8'h11},
        {1'b1, 1'b1, 8'h33, 1'b1, 1'b0, 8'h22},
        {1'b1, 1'b0, 8'h44, 1'b1, 1'b0, 8'h22},
        {1'b1, 1'b0, 8'h55, 1'b1, 1'b1, 8'h22},
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h33},
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h44},
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h55},
        {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00},
        {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_enable = 1'b1;
    logic       start_bit = 1'b0;
    logic       char_done = 1'b0;
    logic [7:0] char_data = 8'h00;
    logic       char_fe = 1'b0;
    logic       char_pe = 1'b0;
    logic       char_brk = 1'b0;
    logic       line_mark = 1'b0;
    logic       rd_stb = 1'b0;
    logic       cmd_rst_rx = 1'b0;
    logic       cmd_rst_err = 1'b0;
    logic       cmd_rst_brkchg = 1'b0;
    logic       cmd_acc_load = 1'b0;
    logic       cmd_acc_read = 1'b0;
    logic [7:0] rd_data;
    logic       rx_rdy, rx_full, st_overrun, st_frame, st_parity, st_break, brk_chg_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rx_status_tracker #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .start_bit(start_bit),
        .char_done(char_done), .char_data(char_data), .char_fe(char_fe),
        .char_pe(char_pe), .char_brk(char_brk), .line_mark(line_mark),
        .rd_stb(rd_stb), .cmd_rst_rx(cmd_rst_rx), .cmd_rst_err(cmd_rst_err),
        .cmd_rst_brkchg(cmd_rst_brkchg), .cmd_acc_load(cmd_acc_load),
        .cmd_acc_read(cmd_acc_read), .rd_data(rd_data), .rx_rdy(rx_rdy),
        .rx_full(rx_full), .st_overrun(st_overrun), .st_frame(st_frame),
        .st_parity(st_parity), .st_break(st_break), .brk_chg_irq(brk_chg_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input bit ld, input logic [7:0] d, input bit fe, input bit pe,
                         input bit brk, input bit rd, input bit st, input bit mk,
                         input logic [4:0] cmd);
        char_done = ld; char_data = d; char_fe = fe; char_pe = pe; char_brk = brk;
        rd_stb = rd; start_bit = st; line_mark = mk;
        {cmd_acc_read, cmd_acc_load, cmd_rst_brkchg, cmd_rst_err, cmd_rst_rx} = cmd;
        @(negedge clk);
        char_done = 1'b0; char_fe = 1'b0; char_pe = 1'b0; char_brk = 1'b0;
        rd_stb = 1'b0; start_bit = 1'b0; line_mark = 1'b0;
        {cmd_acc_read, cmd_acc_load, cmd_rst_brkchg, cmd_rst_err, cmd_rst_rx} = C_NONE;
    endtask

    task automatic load(input logic [7:0] d, input bit fe, input bit pe, input bit brk);
        drive(1'b1, d, fe, pe, brk, 1'b0, 1'b0, 1'b0, C_NONE);
    endtask

    task automatic read1();
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, C_NONE);
    endtask

    task automatic command(input logic [4:0] c);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, c);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 rx_rdy", rx_rdy, 0);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 status bits", {st_overrun, st_frame, st_parity, st_break}, 0);
        chk("R1 brk_chg_irq", brk_chg_irq, 0);

        // R2 R3: vector table
        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            v = VEC[i];
            drive(v[19], v[17:10], 1'b0, 1'b0, 1'b0, v[18], 1'b0, 1'b0, C_NONE);
            chk($sformatf("R2 vec%0d rx_rdy", i), rx_rdy, v[9]);
            chk($sformatf("R4 vec%0d rx_full", i), rx_full, v[8]);
            if (v[9]) chk($sformatf("R3 vec%0d rd_data", i), rd_data, v[7:0]);
        end

        // R4: holding register keeps rx_full up to the second read
        load(8'h01, 0, 0, 0); load(8'h02, 0, 0, 0); load(8'h03, 0, 0, 0); load(8'h04, 0, 0, 0);
        chk("R4 full after filling", rx_full, 1);
        load(8'h05, 0, 0, 0);
        read1();
        chk("R4 full after first read", rx_full, 1);
        chk("R4 head after first read", rd_data, 8'h02);
        read1();
        chk("R4 full after second read", rx_full, 0);
        chk("R4 head after second read", rd_data, 8'h03);
        read1(); read1();
        chk("R4 held char reached store", rd_data, 8'h05);
        read1();
        chk("R2 empty after drain", rx_rdy, 0);

        // R5: overrun and discard
        load(8'hA1, 0, 0, 0); load(8'hA2, 0, 0, 0); load(8'hA3, 0, 0, 0); load(8'hA4, 0, 0, 0);
        load(8'hA5, 0, 0, 0);
        chk("R5 no overrun before start", st_overrun, 0);
        drive(1'b0, 8'h00, 0, 0, 0, 1'b0, 1'b1, 1'b0, C_NONE);
        chk("R5 overrun set", st_overrun, 1);
        load(8'h99, 1, 1, 0);
        read1(); read1(); read1();
        chk("R5 order kept", rd_data, 8'hA4);
        read1();
        chk("R5 last kept char", rd_data, 8'hA5);
        chk("R5 discarded flags not read", {st_frame, st_parity}, 0);
        read1();
        chk("R5 discarded char absent", rx_rdy, 0);
        command(C_ERR);
        chk("R8 overrun cleared", st_overrun, 0);

        // R6: read-side error bits
        load(8'h10, 1, 0, 0);
        chk("R6 frame not set on load", st_frame, 0);
        load(8'h20, 0, 1, 0);
        chk("R6 parity not set on load", st_parity, 0);
        read1();
        chk("R6 frame set on read", {st_frame, st_parity}, 2'b10);
        read1();
        chk("R6 parity set on read", {st_frame, st_parity}, 2'b11);
        command(C_ERR);
        chk("R8 frame parity cleared", {st_frame, st_parity}, 0);

        // R7: load-accumulate mode
        command(C_LOADM);
        load(8'h30, 0, 1, 0);
        chk("R7 parity set on load", st_parity, 1);
        read1();
        command(C_READM);
        command(C_ERR);
        load(8'h40, 1, 0, 0);
        chk("R7 back to read side", st_frame, 0);

        // R8: clear wins over a same-cycle set
        drive(1'b0, 8'h00, 0, 0, 0, 1'b1, 1'b0, 1'b0, C_ERR);
        chk("R8 clear wins", st_frame, 0);
        chk("R2 empty after read", rx_rdy, 0);

        // R9 R10: break handling
        load(8'hAA, 0, 0, 1);
        chk("R9 break entry stored", rx_rdy, 1);
        chk("R9 break entry data", rd_data, 8'h00);
        chk("R10 irq on break", brk_chg_irq, 1);
        chk("R6 break bit waits for read", st_break, 0);
        load(8'h61, 0, 0, 0);
        command(C_CHG);
        chk("R10 irq cleared", brk_chg_irq, 0);
        drive(1'b0, 8'h00, 0, 0, 0, 1'b0, 1'b0, 1'b1, C_NONE);
        chk("R10 irq on break end", brk_chg_irq, 1);
        drive(1'b0, 8'h00, 0, 0, 0, 1'b0, 1'b0, 1'b1, C_CHG);
        chk("R10 clear while marking in hunt", brk_chg_irq, 0);
        load(8'h62, 0, 0, 0);
        read1();
        chk("R9 blocked char dropped", rd_data, 8'h62);
        chk("R6 break bit on read", st_break, 1);
        read1();
        chk("R9 single break entry", rx_rdy, 0);
        command(C_ERR);

        // R11: reset receiver
        load(8'h71, 0, 0, 0); load(8'h72, 0, 0, 0);
        command(C_RX);
        chk("R11 store emptied", rx_rdy, 0);
        load(8'h73, 0, 0, 0);
        chk("R11 fresh head", rd_data, 8'h73);
        read1();

        // R12: disable keeps contents and ignores events
        load(8'h81, 0, 0, 0);
        rx_enable = 1'b0;
        load(8'h82, 0, 0, 0);
        chk("R12 contents kept", rd_data, 8'h81);
        rx_enable = 1'b1;
        load(8'h83, 0, 0, 0);
        read1();
        chk("R12 appended after enable", rd_data, 8'h83);
        read1();
        chk("R12 ignored char absent", rx_rdy, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule